// File: doc/BRIEF.md
# Variable-Page Translation Lookaside Buffer

This block translates 32-bit effective addresses into physical addresses by searching a 32-entry table in one parallel compare. A lookup presents an effective address, an address-space bit, an 8-bit process ID, an access type (read, write or execute) and the privilege mode. One clock later the block reports a hit or a miss, the physical address, the attributes of the page and a permission-fault flag. If several entries match, it also raises a multi-hit flag.

Each entry has its own page size, from 4 KB to 256 MB in powers of four. The size code decides how many low bits of the page number take part in the compare, and those same bits are passed through from the effective address into the physical address. Software fills the table through a register-style port: an index, a write strobe, a flat entry word and a combinational read-back of the indexed entry. A single strobe invalidates every entry that is not marked as protected.

Top module: `tlb_xlate`

## Requirements
- R1: A write stores `cfg_wdata` into the entry chosen by `cfg_idx` at the clock edge. `cfg_rdata` shows the entry chosen by `cfg_idx` combinationally. The entry word layout is: bit 70 valid, bit 69 space bit, bits 68:61 ID, bits 60:41 effective page, bits 40:21 real page, bits 20:17 size code, bits 16:11 permissions, bits 10:6 attributes, bits 5:2 software bits, bit 1 protect, bit 0 variable-length flag.
- R2: After reset every entry is invalid, every lookup misses and all response outputs are zero.
- R3: `rsp_valid` is high in exactly the cycle after a cycle with `lk_req` high. While `rsp_valid` is low, all other response outputs are zero.
- R4: An entry matches only when it is valid, its space bit equals `lk_as`, and its effective page equals `lk_ea[31:12]` on the bits its size keeps.
- R5: An entry's ID must equal `lk_pid` for a match, unless the entry's ID is zero, in which case the entry matches any process ID.
- R6: Size code n (1 to 9) selects a page of 4 KB·4^(n−1). The low 2·(n−1) page-number bits are left out of the compare. `rsp_pa` takes the real page on the kept bits, and `lk_ea` on the left-out bits and on bits 11:0.
- R7: Size codes 0 and 10 to 15 behave as 4 KB pages.
- R8: On a hit, `rsp_fault` is the inverse of the selected permission bit. The permission field is bit 5 supervisor execute, 4 supervisor write, 3 supervisor read, 2 user execute, 1 user write, 0 user read. `lk_acc` codes are 0 read, 1 write, 2 execute, and 3 is treated as read. `lk_super`=1 selects the supervisor bits.
- R9: A lookup that matches no entry gives `rsp_miss`=1, `rsp_hit`=0 and `rsp_fault`=0, with the address and attribute outputs at zero.
- R10: When several entries match, the entry with the lowest index supplies the result and `rsp_multi` is 1. With a single match, `rsp_multi` is 0.
- R11: `cfg_inval_all` clears the valid bit of every entry whose protect bit is 0 in one clock. Protected entries are left unchanged. A lookup in the next cycle sees the result.
- R12: On a hit, `rsp_attr`, `rsp_ubits`, `rsp_iprot` and `rsp_vle` carry the matching entry's attributes, software bits, protect bit and variable-length flag.
- R13: In a cycle with both `cfg_wr` and `cfg_inval_all` high, the written entry takes the new word, including its valid bit. A lookup issued in the same cycle as a write sees the table as it was before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request strobe |
| lk_ea | input | 32 | Effective address |
| lk_as | input | 1 | Address-space bit of the request |
| lk_pid | input | 8 | Process ID of the request |
| lk_acc | input | 2 | Access type: 0 read, 1 write, 2 execute |
| lk_super | input | 1 | 1 for supervisor mode, 0 for user mode |
| cfg_idx | input | 5 | Entry index for write and read-back |
| cfg_wr | input | 1 | Entry write strobe |
| cfg_wdata | input | 71 | Entry word to write |
| cfg_inval_all | input | 1 | Invalidate all unprotected entries |
| cfg_rdata | output | 71 | Indexed entry word |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | At least one entry matched |
| rsp_miss | output | 1 | No entry matched |
| rsp_fault | output | 1 | Permission denied on a hit |
| rsp_multi | output | 1 | More than one entry matched |
| rsp_pa | output | 32 | Physical address |
| rsp_attr | output | 5 | Attribute bits of the matching entry |
| rsp_ubits | output | 4 | Software bits of the matching entry |
| rsp_iprot | output | 1 | Protect bit of the matching entry |
| rsp_vle | output | 1 | Variable-length flag of the matching entry |

## Verification
The checker watches every cycle for the following: response timing after each request, zero outputs when no response is present, hit and miss being mutually exclusive, a miss carrying no fault, multi-hit or address, the page offset passing through to the physical address, write read-back, and the effect of invalidation on the entry being read. Other properties need a model of the whole table and are shown only by the bench. These are which entry wins a multi-hit, the masking for each page size including the out-of-range codes, the ID and space-bit filters, the choice of permission bit, and the pre-write view of a lookup issued in the same cycle as a write. The bench checks them with sweeps over every entry, every access type and both modes, plus random miss traffic.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int EA_W      = 32;
  localparam int OFS_W     = 12;
  localparam int PN_W      = EA_W - OFS_W;
  localparam int TID_W     = 8;
  localparam int SZ_W      = 4;
  localparam int NUM_SIZES = 9;
  localparam int PERM_W    = 6;
  localparam int ATTR_W    = 5;
  localparam int UBIT_W    = 4;

  typedef struct packed {
    logic              ts;
    logic [TID_W-1:0]  tid;
    logic [PN_W-1:0]   epn;
    logic [PN_W-1:0]   rpn;
    logic [SZ_W-1:0]   size;
    logic [PERM_W-1:0] perm;
    logic [ATTR_W-1:0] attr;
    logic [UBIT_W-1:0] ubits;
    logic              iprot;
    logic              vle;
  } tlb_body_t;

  typedef struct packed {
    logic      valid;
    tlb_body_t body;
  } tlb_entry_t;

  localparam int ENTRY_W = $bits(tlb_entry_t);

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_SPARE = 2'd3
  } acc_e;

  typedef struct packed {
    logic              valid;
    logic              hit;
    logic              miss;
    logic              fault;
    logic              multi;
    logic [EA_W-1:0]   pa;
    logic [ATTR_W-1:0] attr;
    logic [UBIT_W-1:0] ubits;
    logic              iprot;
    logic              vle;
  } tlb_rsp_t;

  // Page-number bits that take part in the compare for a size code.
  function automatic logic [PN_W-1:0] page_mask(input logic [SZ_W-1:0] code);
    logic [PN_W-1:0] m;
    m = {PN_W{1'b1}};
    for (int n = 2; n <= NUM_SIZES; n++) begin
      if (int'(code) == n) m = {PN_W{1'b1}} << (2 * (n - 1));
    end
    return m;
  endfunction

  // Upper three bits: supervisor x/w/r, lower three: user x/w/r.
  function automatic logic perm_ok(input logic [PERM_W-1:0] perm,
                                   input acc_e acc, input logic sup);
    logic [2:0] xwr;
    xwr = sup ? perm[5:3] : perm[2:0];
    case (acc)
      ACC_FETCH: return xwr[2];
      ACC_STORE: return xwr[1];
      default:   return xwr[0];
    endcase
  endfunction
endpackage

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  tlb_entry_t       wr_data,
  input  logic             inval_all,
  input  logic [IDX_W-1:0] rd_idx,
  output tlb_entry_t       rd_data,
  output tlb_entry_t       entries [ENTRIES]
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic      vld_q, vld_d, vld_en;
    tlb_body_t body_q;
    logic      body_en;

    always_comb begin
      body_en = wr_en && (wr_idx == IDX_W'(g));
      vld_d   = vld_q;
      if (inval_all && !body_q.iprot) vld_d = 1'b0;
      if (body_en) vld_d = wr_data.valid;
      vld_en  = body_en || inval_all;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      vld_q <= 1'b0;
      else if (vld_en) vld_q <= vld_d;
    end

    always_ff @(posedge clk) begin
      if (body_en) body_q <= wr_data.body;
    end

    assign entries[g] = '{valid: vld_q, body: body_q};
  end

  assign rd_data = entries[rd_idx];
endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32
) (
  input  logic [ENTRIES-1:0] ent_vld,
  input  logic [ENTRIES-1:0] ent_ts,
  input  logic [TID_W-1:0]   ent_tid  [ENTRIES],
  input  logic [PN_W-1:0]    ent_epn  [ENTRIES],
  input  logic [SZ_W-1:0]    ent_size [ENTRIES],
  input  logic [PN_W-1:0]    req_pn,
  input  logic               req_as,
  input  logic [TID_W-1:0]   req_pid,
  output logic [ENTRIES-1:0] hit_vec
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic [PN_W-1:0] keep;
    logic            pn_eq, id_ok;
    assign keep       = page_mask(ent_size[g]);
    assign pn_eq      = ((ent_epn[g] ^ req_pn) & keep) == '0;
    assign id_ok      = (ent_tid[g] == '0) || (ent_tid[g] == req_pid);
    assign hit_vec[g] = ent_vld[g] && (ent_ts[g] == req_as) && id_ok && pn_eq;
  end
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
  parameter int ENTRIES = 32,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] hit_vec,
  output logic               any,
  output logic               multi,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) idx = IDX_W'(i);
    end
  end

  assign any   = |hit_vec;
  assign multi = (hit_vec & (hit_vec - 1'b1)) != '0;
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_req,
  input  logic [EA_W-1:0]    lk_ea,
  input  logic               lk_as,
  input  logic [TID_W-1:0]   lk_pid,
  input  logic [1:0]         lk_acc,
  input  logic               lk_super,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic               cfg_wr,
  input  logic [ENTRY_W-1:0] cfg_wdata,
  input  logic               cfg_inval_all,
  output logic [ENTRY_W-1:0] cfg_rdata,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic               rsp_miss,
  output logic               rsp_fault,
  output logic               rsp_multi,
  output logic [EA_W-1:0]    rsp_pa,
  output logic [ATTR_W-1:0]  rsp_attr,
  output logic [UBIT_W-1:0]  rsp_ubits,
  output logic               rsp_iprot,
  output logic               rsp_vle
);
  // Reset: asserted asynchronously, released through two flops.
  logic rst_meta, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  tlb_entry_t entries [ENTRIES];
  tlb_entry_t rd_ent;

  tlb_store #(.ENTRIES(ENTRIES)) u_store (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .wr_en     (cfg_wr),
    .wr_idx    (cfg_idx),
    .wr_data   (tlb_entry_t'(cfg_wdata)),
    .inval_all (cfg_inval_all),
    .rd_idx    (cfg_idx),
    .rd_data   (rd_ent),
    .entries   (entries)
  );
  assign cfg_rdata = rd_ent;

  logic [ENTRIES-1:0] k_vld, k_ts;
  logic [TID_W-1:0]   k_tid  [ENTRIES];
  logic [PN_W-1:0]    k_epn  [ENTRIES];
  logic [SZ_W-1:0]    k_size [ENTRIES];
  for (genvar g = 0; g < ENTRIES; g++) begin : g_key
    assign k_vld[g]  = entries[g].valid;
    assign k_ts[g]   = entries[g].body.ts;
    assign k_tid[g]  = entries[g].body.tid;
    assign k_epn[g]  = entries[g].body.epn;
    assign k_size[g] = entries[g].body.size;
  end

  logic [ENTRIES-1:0] hit_vec;
  tlb_match #(.ENTRIES(ENTRIES)) u_match (
    .ent_vld  (k_vld),
    .ent_ts   (k_ts),
    .ent_tid  (k_tid),
    .ent_epn  (k_epn),
    .ent_size (k_size),
    .req_pn   (lk_ea[EA_W-1:OFS_W]),
    .req_as   (lk_as),
    .req_pid  (lk_pid),
    .hit_vec  (hit_vec)
  );

  logic             any_hit, multi_hit;
  logic [IDX_W-1:0] sel_idx;
  tlb_pick #(.ENTRIES(ENTRIES)) u_pick (
    .hit_vec (hit_vec),
    .any     (any_hit),
    .multi   (multi_hit),
    .idx     (sel_idx)
  );

  // Next-state of the response register.
  logic [PN_W-1:0] sel_keep, sel_pn;
  tlb_rsp_t        rsp_d, rsp_q;
  logic            rsp_en;

  always_comb begin
    sel_keep = page_mask(entries[sel_idx].body.size);
    sel_pn   = (entries[sel_idx].body.rpn & sel_keep)
             | (lk_ea[EA_W-1:OFS_W] & ~sel_keep);
    rsp_d    = '0;
    if (lk_req) begin
      rsp_d.valid = 1'b1;
      if (any_hit) begin
        rsp_d.hit   = 1'b1;
        rsp_d.multi = multi_hit;
        rsp_d.fault = !perm_ok(entries[sel_idx].body.perm, acc_e'(lk_acc), lk_super);
        rsp_d.pa    = {sel_pn, lk_ea[OFS_W-1:0]};
        rsp_d.attr  = entries[sel_idx].body.attr;
        rsp_d.ubits = entries[sel_idx].body.ubits;
        rsp_d.iprot = entries[sel_idx].body.iprot;
        rsp_d.vle   = entries[sel_idx].body.vle;
      end else begin
        rsp_d.miss  = 1'b1;
      end
    end
    rsp_en = lk_req || rsp_q.valid;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    rsp_q <= '0;
    else if (rsp_en) rsp_q <= rsp_d;
  end

  assign rsp_valid = rsp_q.valid;
  assign rsp_hit   = rsp_q.hit;
  assign rsp_miss  = rsp_q.miss;
  assign rsp_fault = rsp_q.fault;
  assign rsp_multi = rsp_q.multi;
  assign rsp_pa    = rsp_q.pa;
  assign rsp_attr  = rsp_q.attr;
  assign rsp_ubits = rsp_q.ubits;
  assign rsp_iprot = rsp_q.iprot;
  assign rsp_vle   = rsp_q.vle;
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_req,
  input logic [EA_W-1:0]    lk_ea,
  input logic [IDX_W-1:0]   cfg_idx,
  input logic               cfg_wr,
  input logic [ENTRY_W-1:0] cfg_wdata,
  input logic               cfg_inval_all,
  input logic [ENTRY_W-1:0] cfg_rdata,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic               rsp_miss,
  input logic               rsp_fault,
  input logic               rsp_multi,
  input logic [EA_W-1:0]    rsp_pa,
  input logic [ATTR_W-1:0]  rsp_attr,
  input logic [UBIT_W-1:0]  rsp_ubits,
  input logic               rsp_iprot,
  input logic               rsp_vle
);
  tlb_entry_t rd;
  assign rd = tlb_entry_t'(cfg_rdata);

  a_r3_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> rsp_valid);
  a_r3_no_req_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !rsp_valid);
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_hit && !rsp_miss && !rsp_fault && !rsp_multi && rsp_pa == '0));
  a_r9_hit_xor_miss: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit != rsp_miss));
  a_r9_miss_clean: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> (!rsp_fault && !rsp_multi && rsp_pa == '0 && rsp_attr == '0
                  && rsp_ubits == '0 && !rsp_iprot && !rsp_vle));
  a_r10_multi_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_multi |-> rsp_hit);
  a_r6_offset_through: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_pa[OFS_W-1:0] == $past(lk_ea[OFS_W-1:0]));
  a_r1_write_readback: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (cfg_idx != $past(cfg_idx)) || (cfg_rdata == $past(cfg_wdata)));
  a_r11_inval_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_inval_all && !cfg_wr && !rd.body.iprot) |=> (cfg_idx != $past(cfg_idx)) || !rd.valid);
  a_r11_inval_keeps_protected: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_inval_all && !cfg_wr && rd.body.iprot) |=> (cfg_idx != $past(cfg_idx))
                                                    || (cfg_rdata == $past(cfg_rdata)));
endmodule

bind tlb_xlate tlb_xlate_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n_s),
  .lk_req        (lk_req),
  .lk_ea         (lk_ea),
  .cfg_idx       (cfg_idx),
  .cfg_wr        (cfg_wr),
  .cfg_wdata     (cfg_wdata),
  .cfg_inval_all (cfg_inval_all),
  .cfg_rdata     (cfg_rdata),
  .rsp_valid     (rsp_valid),
  .rsp_hit       (rsp_hit),
  .rsp_miss      (rsp_miss),
  .rsp_fault     (rsp_fault),
  .rsp_multi     (rsp_multi),
  .rsp_pa        (rsp_pa),
  .rsp_attr      (rsp_attr),
  .rsp_ubits     (rsp_ubits),
  .rsp_iprot     (rsp_iprot),
  .rsp_vle       (rsp_vle)
);

// File: tb/tlb_xlate_test.sv
module tlb_xlate_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_req, lk_as, lk_super;
  logic [31:0] lk_ea;
  logic [7:0]  lk_pid;
  logic [1:0]  lk_acc;
  logic [4:0]  cfg_idx;
  logic        cfg_wr, cfg_inval_all;
  logic [70:0] cfg_wdata, cfg_rdata;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_multi, rsp_iprot, rsp_vle;
  logic [31:0] rsp_pa;
  logic [4:0]  rsp_attr;
  logic [3:0]  rsp_ubits;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tlb_xlate uut (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_ea(lk_ea), .lk_as(lk_as),
    .lk_pid(lk_pid), .lk_acc(lk_acc), .lk_super(lk_super), .cfg_idx(cfg_idx),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_inval_all(cfg_inval_all),
    .cfg_rdata(cfg_rdata), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_miss(rsp_miss), .rsp_fault(rsp_fault), .rsp_multi(rsp_multi),
    .rsp_pa(rsp_pa), .rsp_attr(rsp_attr), .rsp_ubits(rsp_ubits),
    .rsp_iprot(rsp_iprot), .rsp_vle(rsp_vle)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] seed = 32'h1234_5678;
  logic [70:0] mdl [N];

  logic        e_hit, e_multi, e_fault;
  logic [31:0] e_pa;
  logic [10:0] e_side;

  function logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] keep_of(input logic [3:0] sz);
    int k;
    k = (sz >= 4'd1 && sz <= 4'd9) ? 2 * (int'(sz) - 1) : 0;
    return 20'hFFFFF << k;
  endfunction

  // Expected result from the requirements, over the bench copy of the table.
  task automatic model(input logic [31:0] ea, input logic as, input logic [7:0] pid,
                       input logic [1:0] acc, input logic sup);
    int cnt;
    int sel;
    cnt = 0; sel = 0;
    for (int i = N - 1; i >= 0; i--) begin
      logic [70:0] e;
      logic [19:0] m;
      e = mdl[i];
      m = keep_of(e[20:17]);
      if (e[70] && e[69] == as && (e[68:61] == 8'd0 || e[68:61] == pid)
          && ((ea[31:12] ^ e[60:41]) & m) == 20'd0) begin
        cnt++;
        sel = i;
      end
    end
    e_hit = cnt > 0; e_multi = cnt > 1; e_fault = 1'b0; e_pa = '0; e_side = '0;
    if (e_hit) begin
      logic [70:0] e;
      logic [19:0] m;
      int pb;
      e  = mdl[sel];
      m  = keep_of(e[20:17]);
      pb = (sup ? 3 : 0) + (acc == 2'd2 ? 2 : (acc == 2'd1 ? 1 : 0));
      e_fault = !e[11 + pb];
      e_pa    = {(e[40:21] & m) | (ea[31:12] & ~m), ea[11:0]};
      e_side  = e[10:0];
    end
  endtask

  task automatic compare(input string htag);
    check(htag, 64'(rsp_hit), 64'(e_hit));
    check("R9 miss", 64'(rsp_miss), 64'(!e_hit));
    check("R3 valid", 64'(rsp_valid), 64'd1);
    check("R8 fault", 64'(rsp_fault), 64'(e_fault));
    check("R10 multi", 64'(rsp_multi), 64'(e_multi));
    check("R6 pa", 64'(rsp_pa), 64'(e_pa));
    check("R12 attrs", 64'({rsp_attr, rsp_ubits, rsp_iprot, rsp_vle}), 64'(e_side));
  endtask

  task automatic lookup(input logic [31:0] ea, input logic as, input logic [7:0] pid,
                        input logic [1:0] acc, input logic sup, input string htag);
    model(ea, as, pid, acc, sup);
    @(negedge clk);
    lk_req = 1'b1; lk_ea = ea; lk_as = as; lk_pid = pid; lk_acc = acc; lk_super = sup;
    @(negedge clk);
    lk_req = 1'b0;
    compare(htag);
  endtask

  task automatic write_ent(input int idx, input logic [70:0] w);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_idx = 5'(idx); cfg_wdata = w;
    @(negedge clk);
    cfg_wr = 1'b0;
    mdl[idx] = w;
  endtask

  task automatic readback(input int idx, input string tag);
    cfg_idx = 5'(idx);
    #1;
    check(tag, 64'(cfg_rdata), 64'(mdl[idx]));
  endtask

  function automatic logic [70:0] make_ent(input int i);
    logic [31:0] a, b;
    logic [3:0]  sz;
    logic [7:0]  tid;
    a = rnd(); b = rnd();
    sz  = (i < 27) ? 4'((i % 9) + 1) : ((i == 27) ? 4'd0 : 4'(10 + i - 28));
    tid = (i % 4 == 0) ? 8'd0 : (a[7:0] | 8'd1);
    return {1'b1, a[8], tid, a[31:12], b[19:0], sz, b[25:20], b[30:26], a[11:9], b[31],
            1'((i % 3) == 0), a[10]};
  endfunction

  task automatic sweep_targets();
    for (int i = 0; i < N; i++) begin
      logic [70:0] e;
      logic [19:0] m;
      logic [31:0] r, ea;
      logic [7:0]  pid;
      e = mdl[i];
      m = keep_of(e[20:17]);
      for (int acc = 0; acc < 3; acc++) begin
        for (int sup = 0; sup < 2; sup++) begin
          r   = rnd();
          ea  = {(e[60:41] & m) | (r[31:12] & ~m), r[11:0]};
          pid = (e[68:61] == 8'd0) ? r[7:0] : e[68:61];
          lookup(ea, e[69], pid, 2'(acc), 1'(sup), (i >= 27) ? "R7 hit" : "R4 hit");
        end
      end
      r   = rnd();
      ea  = {(e[60:41] & m) | (r[31:12] & ~m), r[11:0]};
      lookup(ea, !e[69], e[68:61], 2'd0, 1'b1, "R4 hit");
      pid = (e[68:61] == 8'd0) ? r[15:8] : (e[68:61] + 8'd1);
      lookup(ea, e[69], pid, 2'd1, 1'b0, "R5 hit");
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lk_req = 1'b0; lk_ea = '0; lk_as = 1'b0; lk_pid = '0; lk_acc = '0;
    lk_super = 1'b0; cfg_idx = '0; cfg_wr = 1'b0; cfg_wdata = '0; cfg_inval_all = 1'b0;
    for (int i = 0; i < N; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: reset state
    check("R2 rsp_valid", 64'(rsp_valid), 64'd0);
    check("R2 rsp_pa", 64'(rsp_pa), 64'd0);
    for (int i = 0; i < N; i++) begin
      cfg_idx = 5'(i);
      #1;
      check("R2 entry valid", 64'(cfg_rdata[70]), 64'd0);
    end
    lookup(32'h0000_1000, 1'b0, 8'd0, 2'd0, 1'b0, "R2 hit");

    // R3: outputs quiet the cycle after an idle cycle
    @(negedge clk);
    check("R3 idle valid", 64'(rsp_valid), 64'd0);
    check("R3 idle miss", 64'(rsp_miss), 64'd0);

    // R1: fill and read back
    for (int i = 0; i < N; i++) write_ent(i, make_ent(i));
    for (int i = 0; i < N; i++) readback(i, "R1 readback");

    sweep_targets();

    // R9: random traffic, mostly misses
    for (int k = 0; k < 200; k++) begin
      logic [31:0] a, b;
      a = rnd(); b = rnd();
      lookup(a, b[0], b[15:8], 2'(b[17:16]), b[18], "R9 hit");
    end

    // R10: two entries on the same page, lowest index wins
    begin
      logic [70:0] w5, w20;
      w5  = {1'b1, 1'b0, 8'd0, 20'hABCDE, 20'h11111, 4'd1, 6'h3F, 5'h0A, 4'h5, 1'b0, 1'b1};
      w20 = {1'b1, 1'b0, 8'd0, 20'hABCDE, 20'h22222, 4'd1, 6'h00, 5'h15, 4'hA, 1'b1, 1'b0};
      write_ent(20, w20);
      write_ent(5, w5);
      lookup(32'hABCD_E123, 1'b0, 8'h77, 2'd0, 1'b0, "R10 hit");
      check("R10 lowest index pa", 64'(rsp_pa), 64'h1111_1123);
      check("R10 multi flag", 64'(rsp_multi), 64'd1);
    end

    // R13 + R11: write and invalidate-all in one cycle, lookup sees old table
    begin
      logic [70:0] w2, old2;
      logic [31:0] ea;
      old2 = mdl[2];
      ea   = {old2[60:41], 12'h456};
      w2   = {1'b1, 1'b1, 8'h42, 20'h0F0F0, 20'h12345, 4'd3, 6'h2A, 5'h11, 4'h3, 1'b0, 1'b0};
      model(ea, old2[69], old2[68:61], 2'd0, 1'b1);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_idx = 5'd2; cfg_wdata = w2; cfg_inval_all = 1'b1;
      lk_req = 1'b1; lk_ea = ea; lk_as = old2[69]; lk_pid = old2[68:61];
      lk_acc = 2'd0; lk_super = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0; cfg_inval_all = 1'b0; lk_req = 1'b0;
      compare("R13 hit");
      for (int i = 0; i < N; i++) if (!mdl[i][1]) mdl[i][70] = 1'b0;
      mdl[2] = w2;
      readback(2, "R13 write wins");
      for (int i = 0; i < N; i++) if (i != 2) readback(i, "R11 readback");
    end
    sweep_targets();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule